// File: doc/BRIEF.md
# Fine-Adjustable Nanosecond Time-of-Day Clock

This block keeps a free-running 40-bit nanosecond time-of-day count for packet timestamping. On every enabled clock cycle (one tick) the count grows by a fixed nominal step of 8 ns. A signed fractional trim, held in a sign-magnitude adjust register, adds into or subtracts from a 32-bit sub-nanosecond accumulator on each tick. When that accumulator carries, the tick's step becomes 9 ns. When it borrows, the step becomes 7 ns. Software can therefore trim the rate in parts per billion without ever touching the nominal step.

Software reaches the block through a simple 32-bit register port with one-cycle read and write strobes. Multi-word reads are coherent: reading the sub-nanosecond word returns the live fraction and, at the same clock edge, freezes the whole nanosecond count into a shadow copy. Later reads of the low and high time words return that frozen copy. Multi-word writes are coherent too: the sub-nanosecond and low words are staged, and writing the high word commits all three in one clock edge.

Register addresses on `reg_addr`:
- 0: control. Bit 31 is the timer-off flag.
- 1: rate adjust. Bit 31 is the sign, bits 30:0 are the magnitude.
- 2: sub-nanosecond word.
- 3: time low word.
- 4: time high word. Only bits 7:0 are used.

Top module: `ptp_fine_clock`

## Requirements
- R1: After reset the control register reads 0x8000_0000 (timer off), the adjust register reads 0, and the time count, fraction and shadow all read 0.
- R2: While control bit 31 is 1, the nanosecond count and the sub-nanosecond accumulator hold their values from tick to tick.
- R3: While control bit 31 is 0 and the adjust magnitude is 0, the count grows by exactly 8 per tick and the fraction does not change.
- R4: With the adjust sign bit 31 at 0, each tick adds the magnitude (bits 30:0, units of 2^-32 ns) to the fraction modulo 2^32. A carry out makes that tick's step 9 ns. A magnitude of 0x4000_0000 gives exactly 66 ns over any 8 ticks.
- R5: With the sign bit at 1, each tick subtracts the magnitude from the fraction modulo 2^32. A borrow makes that tick's step 7 ns. A magnitude of 0x4000_0000 gives exactly 62 ns over any 8 ticks.
- R6: Reading address 2 returns the live fraction and captures the count into a shadow at that edge. Reads of address 3 then return shadow bits 31:0 unchanged until the next address-2 read.
- R7: Reading address 4 returns shadow bits 39:32 in bits 7:0, with bits 31:8 always 0.
- R8: Writes to addresses 2 and 3 are only staged. A write to address 4 loads the fraction from staged address 2, count bits 31:0 from staged address 3, and count bits 39:32 from write data bits 7:0, all in one edge. The load replaces that edge's tick and is accepted while the timer is off.
- R9: The count wraps from 0xFF_FFFF_FFF8 by an 8 ns step to 0 with no other effect.
- R10: An adjust write first affects the tick at the following edge. Rewriting the adjust register never clears the fraction.
- R11: The full magnitude 0x7FFF_FFFF (about 62,499,999 ppb) is accepted with either sign, and no tick's step ever falls outside 7 to 9 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; one tick per enabled cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe; matters for the latching read of address 2 |
| reg_addr | input | 3 | Register address (0 to 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |

## Verification
The properties assume each register access is a single-cycle strobe at an address inside the map. They also assume that the word read right after a latching sub-nanosecond read is meant to return the frozen copy. The stimulus keeps to these rules: every access comes from one task that raises one strobe for exactly one edge and then drops it, and it touches only the five defined addresses. Time loads are always issued as staged words followed by the committing high word. Adjust values, including both signs at full magnitude, are applied only through the adjust register while the timer runs.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;
  localparam int OFF_BIT = 31;
  localparam int SGN_BIT = 31;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ADJ   = 3'd1;
  localparam logic [ADDR_W-1:0] A_SUBNS = 3'd2;
  localparam logic [ADDR_W-1:0] A_TLO   = 3'd3;
  localparam logic [ADDR_W-1:0] A_THI   = 3'd4;
endpackage

// File: rtl/ptp_rate_accum.sv
module ptp_rate_accum #(
  parameter int FRAC_W   = 32,
  parameter int NOM_STEP = 8,
  parameter int STEP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              load_en,
  input  logic [FRAC_W-1:0] load_frac,
  input  logic              adj_neg,
  input  logic [FRAC_W-2:0] adj_mag,
  output logic [FRAC_W-1:0] frac_q,
  output logic [STEP_W-1:0] step
);
  logic [FRAC_W:0]   sum_w;
  logic [FRAC_W:0]   dif_w;
  logic [FRAC_W-1:0] frac_d;
  logic [FRAC_W-1:0] frac_tick;

  always_comb begin
    sum_w = {1'b0, frac_q} + {2'b00, adj_mag};
    dif_w = {1'b0, frac_q} - {2'b00, adj_mag};
    if (adj_neg) begin
      frac_tick = dif_w[FRAC_W-1:0];
      step      = STEP_W'(NOM_STEP) - STEP_W'(dif_w[FRAC_W]);
    end else begin
      frac_tick = sum_w[FRAC_W-1:0];
      step      = STEP_W'(NOM_STEP) + STEP_W'(sum_w[FRAC_W]);
    end
  end

  always_comb begin
    frac_d = frac_q;
    if (load_en)      frac_d = load_frac;
    else if (tick_en) frac_d = frac_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frac_q <= '0;
    else        frac_q <= frac_d;
  end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int NS_W   = 40,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              load_en,
  input  logic [NS_W-1:0]   load_ns,
  input  logic [STEP_W-1:0] step,
  output logic [NS_W-1:0]   ns_q
);
  logic [NS_W-1:0] ns_d;

  always_comb begin
    ns_d = ns_q;
    if (load_en)      ns_d = load_ns;
    else if (tick_en) ns_d = ns_q + NS_W'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ns_q <= '0;
    else        ns_q <= ns_d;
  end
endmodule

// File: rtl/ptp_reg_if.sv
module ptp_reg_if
  import ptp_clk_pkg::*;
#(
  parameter int NS_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [NS_W-1:0]   ns_q,
  input  logic [REG_W-1:0]  frac_q,
  output logic              disabled,
  output logic              adj_neg,
  output logic [REG_W-2:0]  adj_mag,
  output logic              load_en,
  output logic [NS_W-1:0]   load_ns,
  output logic [REG_W-1:0]  load_frac
);
  localparam int HI_W = NS_W - REG_W;

  logic             off_q, off_d;
  logic [REG_W-1:0] adj_q, adj_d;
  logic [REG_W-1:0] stg_sub_q, stg_sub_d;
  logic [REG_W-1:0] stg_lo_q, stg_lo_d;
  logic [NS_W-1:0]  shd_q, shd_d;
  logic             wr_ctrl, wr_adj, wr_sub, wr_lo, rd_latch;

  assign wr_ctrl  = wr && (addr == A_CTRL);
  assign wr_adj   = wr && (addr == A_ADJ);
  assign wr_sub   = wr && (addr == A_SUBNS);
  assign wr_lo    = wr && (addr == A_TLO);
  assign load_en  = wr && (addr == A_THI);
  assign rd_latch = rd && (addr == A_SUBNS);

  always_comb begin
    off_d     = wr_ctrl  ? wdata[OFF_BIT] : off_q;
    adj_d     = wr_adj   ? wdata : adj_q;
    stg_sub_d = wr_sub   ? wdata : stg_sub_q;
    stg_lo_d  = wr_lo    ? wdata : stg_lo_q;
    shd_d     = rd_latch ? ns_q  : shd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q     <= 1'b1;
      adj_q     <= '0;
      stg_sub_q <= '0;
      stg_lo_q  <= '0;
      shd_q     <= '0;
    end else begin
      off_q     <= off_d;
      adj_q     <= adj_d;
      stg_sub_q <= stg_sub_d;
      stg_lo_q  <= stg_lo_d;
      shd_q     <= shd_d;
    end
  end

  assign disabled  = off_q;
  assign adj_neg   = adj_q[SGN_BIT];
  assign adj_mag   = adj_q[REG_W-2:0];
  assign load_ns   = {wdata[HI_W-1:0], stg_lo_q};
  assign load_frac = stg_sub_q;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {off_q, {(REG_W-1){1'b0}}};
      A_ADJ:   rdata = adj_q;
      A_SUBNS: rdata = frac_q;
      A_TLO:   rdata = shd_q[REG_W-1:0];
      A_THI:   rdata = {{(REG_W-HI_W){1'b0}}, shd_q[NS_W-1:REG_W]};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ptp_fine_clock.sv
module ptp_fine_clock
  import ptp_clk_pkg::*;
#(
  parameter int NS_W     = 40,
  parameter int NOM_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam int STEP_W = $clog2(NOM_STEP + 2);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              disabled, tick_en, load_en, adj_neg;
  logic [REG_W-2:0]  adj_mag;
  logic [NS_W-1:0]   ns_q, load_ns;
  logic [REG_W-1:0]  frac_q, load_frac;
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];
  assign tick_en    = ~disabled;

  ptp_reg_if #(.NS_W(NS_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ns_q(ns_q), .frac_q(frac_q),
    .disabled(disabled), .adj_neg(adj_neg), .adj_mag(adj_mag),
    .load_en(load_en), .load_ns(load_ns), .load_frac(load_frac)
  );

  ptp_rate_accum #(.FRAC_W(REG_W), .NOM_STEP(NOM_STEP), .STEP_W(STEP_W)) u_accum (
    .clk(clk), .rst_n(rst_sync_n), .tick_en(tick_en), .load_en(load_en),
    .load_frac(load_frac), .adj_neg(adj_neg), .adj_mag(adj_mag),
    .frac_q(frac_q), .step(step)
  );

  ptp_time_counter #(.NS_W(NS_W), .STEP_W(STEP_W)) u_count (
    .clk(clk), .rst_n(rst_sync_n), .tick_en(tick_en), .load_en(load_en),
    .load_ns(load_ns), .step(step), .ns_q(ns_q)
  );
endmodule

// File: rtl/ptp_clk_checker.sv
module ptp_clk_checker
  import ptp_clk_pkg::*;
#(
  parameter int NS_W     = 40,
  parameter int NOM_STEP = 8,
  parameter int STEP_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disabled,
  input logic              load_en,
  input logic [REG_W-2:0]  adj_mag,
  input logic [STEP_W-1:0] step,
  input logic [NS_W-1:0]   ns_q,
  input logic [REG_W-1:0]  frac_q,
  input logic              rd,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic [REG_W-1:0]  rdata
);
  localparam int HI_W = NS_W - REG_W;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (disabled && !load_en) |=> ($stable(ns_q) && $stable(frac_q))); // R2
  AST_NOMINAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!disabled && !load_en && adj_mag == '0) |=> (ns_q == $past(ns_q) + NS_W'(NOM_STEP))); // R3
  AST_FRAC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!disabled && !load_en && adj_mag == '0) |=> $stable(frac_q)); // R10
  AST_SNAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_SUBNS) |=> (!(rd && addr == A_TLO) || rdata == $past(ns_q[REG_W-1:0]))); // R6
  AST_HI_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_THI) |-> (rdata[REG_W-1:HI_W] == '0)); // R7
  AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_THI) |=> (ns_q[NS_W-1:REG_W] == $past(wdata[HI_W-1:0]))); // R8
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !disabled |-> (step >= STEP_W'(NOM_STEP - 1) && step <= STEP_W'(NOM_STEP + 1))); // R11
endmodule

bind ptp_fine_clock ptp_clk_checker #(.NS_W(NS_W), .NOM_STEP(NOM_STEP), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .disabled(disabled), .load_en(load_en),
  .adj_mag(adj_mag), .step(step), .ns_q(ns_q), .frac_q(frac_q),
  .rd(reg_rd), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata)
);

// File: tb/ptp_fine_clock_bench.sv
module ptp_fine_clock_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int    n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit    live = 1'b0;

  longint unsigned m_ns = 0, m_frac = 0, m_shd = 0;
  bit              m_off = 1'b1;
  logic [31:0]     m_adj = '0, m_sub = '0, m_lo = '0;
  localparam longint unsigned TWO32 = 64'h1_0000_0000;
  localparam longint unsigned NSMSK = 64'hFF_FFFF_FFFF;

  always #2 clk = ~clk;

  ptp_fine_clock u_ptp_fine_clock (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // behavioural reference model
  always @(posedge clk) begin
    if (rst_n) begin
      longint unsigned mag;
      int stp;
      if (reg_rd && reg_addr == 3'd2) m_shd = m_ns;
      mag = longint'(m_adj[30:0]);
      if (reg_wr && reg_addr == 3'd4) begin
        m_ns   = {24'd0, reg_wdata[7:0], m_lo};
        m_frac = longint'(m_sub);
      end else if (!m_off) begin
        stp = 8;
        if (m_adj[31]) begin
          if (m_frac < mag) begin m_frac = m_frac + TWO32 - mag; stp = 7; end
          else m_frac = m_frac - mag;
        end else begin
          m_frac = m_frac + mag;
          if (m_frac >= TWO32) begin m_frac = m_frac - TWO32; stp = 9; end
        end
        m_ns = (m_ns + longint'(stp)) & NSMSK;
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_off = reg_wdata[31];
          3'd1: m_adj = reg_wdata;
          3'd2: m_sub = reg_wdata;
          3'd3: m_lo  = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] model_rdata();
    case (reg_addr)
      3'd0: return {m_off, 31'd0};
      3'd1: return m_adj;
      3'd2: return m_frac[31:0];
      3'd3: return m_shd[31:0];
      3'd4: return {24'd0, m_shd[39:32]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (live) check(reg_rdata, model_rdata(), cur_req);
  end

  task automatic op(input bit w, input bit r, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic snap(output logic [31:0] f, output logic [31:0] lo, output logic [31:0] hi);
    op(1'b0, 1'b1, 3'd2, 32'd0); f  = reg_rdata;
    op(1'b0, 1'b1, 3'd3, 32'd0); lo = reg_rdata;
    op(1'b0, 1'b1, 3'd4, 32'd0); hi = reg_rdata;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] f1, l1, h1, f2, l2, h2;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    live = 1'b1;

    cur_req = "R1";
    op(1'b0, 1'b1, 3'd0, 32'd0); check(reg_rdata, 32'h8000_0000, "R1 ctrl");
    op(1'b0, 1'b1, 3'd1, 32'd0); check(reg_rdata, 32'h0, "R1 adj");
    snap(f1, l1, h1);
    check(f1, 0, "R1 frac"); check(l1, 0, "R1 lo"); check(h1, 0, "R1 hi");

    cur_req = "R2";
    idle(6); snap(f1, l1, h1);
    check(l1, 0, "R2 hold lo"); check(f1, 0, "R2 hold frac");

    cur_req = "R3";
    op(1'b1, 1'b0, 3'd0, 32'h0);
    idle(3);
    snap(f1, l1, h1); idle(5); snap(f2, l2, h2);
    check(l2 - l1, 32'd64, "R3 eight ticks");
    check(f2, f1, "R3 frac unchanged");

    cur_req = "R6";
    idle(5); op(1'b0, 1'b1, 3'd3, 32'd0);
    check(reg_rdata, l2, "R6 shadow stable");

    cur_req = "R4";
    op(1'b1, 1'b0, 3'd1, 32'h4000_0000); idle(2);
    snap(f1, l1, h1); idle(5); snap(f2, l2, h2);
    check(l2 - l1, 32'd66, "R4 positive trim");
    check(f2, f1, "R4 frac period");

    cur_req = "R5";
    op(1'b1, 1'b0, 3'd1, 32'hC000_0000); idle(2);
    snap(f1, l1, h1); idle(5); snap(f2, l2, h2);
    check(l2 - l1, 32'd62, "R5 negative trim");
    check(f2, f1, "R5 frac period");

    cur_req = "R11";
    op(1'b1, 1'b0, 3'd1, 32'h7FFF_FFFF); idle(20); snap(f1, l1, h1);
    op(1'b1, 1'b0, 3'd1, 32'hFFFF_FFFF); idle(20); snap(f1, l1, h1);
    op(1'b1, 1'b0, 3'd1, 32'h0);

    cur_req = "R8";
    op(1'b1, 1'b0, 3'd0, 32'h8000_0000);
    op(1'b1, 1'b0, 3'd2, 32'h0000_1234);
    op(1'b1, 1'b0, 3'd3, 32'hFFFF_FFF0);
    snap(f1, l1, h1);
    check(f1 == 32'h1234 ? 32'd1 : 32'd0, 32'd0, "R8 staged only");
    op(1'b1, 1'b0, 3'd4, 32'hABCD_EFFF);
    idle(3); snap(f1, l1, h1);
    check(f1, 32'h0000_1234, "R8 frac load");
    check(l1, 32'hFFFF_FFF0, "R8 lo load");
    cur_req = "R7";
    check(h1, 32'h0000_00FF, "R7 hi reserved zero");

    cur_req = "R9";
    op(1'b1, 1'b0, 3'd0, 32'h0);
    idle(2); snap(f1, l1, h1);
    check(l1, 32'h0, "R9 wrap lo"); check(h1, 32'h0, "R9 wrap hi");

    cur_req = "R10";
    op(1'b1, 1'b0, 3'd1, 32'h4000_0000);
    idle(2);
    op(1'b1, 1'b0, 3'd1, 32'h0);
    op(1'b0, 1'b1, 3'd2, 32'd0); check(reg_rdata, 32'hC000_1234, "R10 next tick");
    idle(3);
    op(1'b0, 1'b1, 3'd2, 32'd0); check(reg_rdata, 32'hC000_1234, "R10 frac kept");

    idle(2);
    live = 1'b0;
    summary();
  end
endmodule